// File: doc/BRIEF.md
# Pull Handshake Requester

This block is the requesting end of a request/acknowledge pull link. Local logic hands it a fetch command on a valid/ready port. The block raises a request line toward a device, optionally carrying an outbound data word, and holds it until the device acknowledges. In the acknowledge cycle it captures the word the device returns. One cycle later it presents that word to local logic together with a single-cycle completion pulse.

A static mode pin selects one of two acknowledge rules. In the two-level rule, acknowledge is high only while the request is high, and the request drops right after the acknowledge cycle. In the return-to-zero rule, the request drops after acknowledge rises, and the device holds acknowledge until it sees the request low. The block then waits for acknowledge to fall before it finishes. A second static pin enables outbound data. Without it, the outbound bus stays at zero.

The command port applies back-pressure with no queueing. `cmd_ready_o` is high only when the block is idle and acknowledge has been low both in the current cycle and in the previous one. A command is taken on a cycle where `cmd_valid_i` and `cmd_ready_o` are both high. A command held while the block is not ready simply waits, and local logic may change it freely until it is taken. Everything runs on one clock with an active-low reset.

Top module: `pull_hs_requester`

## Requirements
- R1: During reset, `req_o`, `done_o` and `busy_o` are 0, `rsp_data_o` and `h_data_o` are 0, and `cmd_ready_o` is 0. One clock edge after reset is released, with acknowledge low, `cmd_ready_o` is 1.
- R2: In the cycle after a command is taken, `req_o` is 1. It stays 1 in every cycle until a clock edge samples `ack_i` high, and it is 0 in the cycle after that edge.
- R3: `cmd_ready_o` is 1 only when the block is idle and `ack_i` is low in the current cycle and the previous cycle. `busy_o` is 1 from the cycle after a command is taken until the block is idle again. Commands offered while the block is busy are not taken.
- R4: `d_data_i` is sampled on the edge that ends the acknowledge cycle. In the following cycle, `done_o` is 1 for exactly one cycle and `rsp_data_o` holds the sampled word.
- R5: When outbound data is enabled, `h_data_o` carries the command word taken with the request. It is unchanged while `req_o` is 1 and `ack_i` is 0. When outbound data is disabled, `h_data_o` is 0.
- R6: In two-level mode (`four_phase_i`=0), after the acknowledge cycle there is one cooldown cycle with `cmd_ready_o`=0. `cmd_ready_o` is 1 again two cycles after the acknowledge cycle.
- R7: In return-to-zero mode (`four_phase_i`=1), after the acknowledge cycle `req_o` stays 0 and `busy_o` stays 1 for as long as `ack_i` stays high. Once a cycle with `ack_i` low has been sampled, one cooldown cycle follows, and `cmd_ready_o` is 1 in the cycle after that.
- R8: `rsp_data_o` changes only in the cycle where `done_o` is 1, and it holds its value until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| four_phase_i | input | 1 | Static: 1 selects the return-to-zero rule |
| bidir_en_i | input | 1 | Static: 1 sends outbound data with each request |
| cmd_valid_i | input | 1 | Fetch command offered |
| cmd_ready_o | output | 1 | Command can be taken this cycle |
| cmd_data_i | input | HW | Outbound word for the command |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rsp_data_o | output | DW | Last word returned by the device |
| req_o | output | 1 | Request line to the device |
| ack_i | input | 1 | Acknowledge from the device |
| h_data_o | output | HW | Outbound data to the device |
| d_data_i | input | DW | Returned data from the device |

## Verification
`req_o` and `h_data_o` change one edge after a command is taken. `done_o` and `rsp_data_o` change one edge after the acknowledge cycle. `cmd_ready_o` returns two edges after the acknowledge cycle in two-level mode, and two edges after the first sampled low acknowledge in return-to-zero mode. It also depends combinationally on the current `ack_i`.

The bench drives its inputs on falling edges and samples the outputs on the following falling edge, so each expected value is checked in the exact cycle it is due. The one exception is the combinational ready path: after changing `ack_i`, the bench waits a short settle delay before sampling `cmd_ready_o`.

// File: rtl/pull_hs_pkg.sv
package pull_hs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_REQ      = 2'd1,
    ST_WAIT_LOW = 2'd2,
    ST_COOL     = 2'd3
  } hs_state_e;
endpackage

// File: rtl/pull_hs_fsm.sv
module pull_hs_fsm
  import pull_hs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic four_phase_i,
  input  logic cmd_valid_i,
  input  logic ack_i,
  output logic cmd_ready_o,
  output logic busy_o,
  output logic req_o,
  output logic accept_o,
  output logic complete_o
);
  hs_state_e state_q, state_d;
  logic      ack_q;

  // Previous acknowledge level; reset high so no request starts until a low is seen.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack_q <= 1'b1;
    else        ack_q <= ack_i;
  end

  assign cmd_ready_o = (state_q == ST_IDLE) && !ack_i && !ack_q;
  assign accept_o    = cmd_valid_i && cmd_ready_o;
  assign complete_o  = (state_q == ST_REQ) && ack_i;
  assign req_o       = (state_q == ST_REQ);
  assign busy_o      = (state_q != ST_IDLE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (accept_o) state_d = ST_REQ;
      ST_REQ:      if (ack_i) state_d = four_phase_i ? ST_WAIT_LOW : ST_COOL;
      ST_WAIT_LOW: if (!ack_i) state_d = ST_COOL;
      ST_COOL:     state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && !ack_i) |=> req_o);
  assert_req_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && ack_i) |=> !req_o);
  assert_ready_ack_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready_o |-> (!ack_i && !$past(ack_i)));
  assert_busy_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !cmd_ready_o);
  assert_two_phase_cool_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!four_phase_i && req_o && ack_i) |=> (!cmd_ready_o && busy_o));
  assert_four_phase_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (four_phase_i && !req_o && busy_o && ack_i) |=> (!req_o && busy_o));
endmodule

// File: rtl/pull_hs_reg.sv
module pull_hs_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q_o <= '0;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/pull_hs_requester.sv
module pull_hs_requester #(
  parameter int HW = 16,
  parameter int DW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          four_phase_i,
  input  logic          bidir_en_i,
  input  logic          cmd_valid_i,
  output logic          cmd_ready_o,
  input  logic [HW-1:0] cmd_data_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] rsp_data_o,
  output logic          req_o,
  input  logic          ack_i,
  output logic [HW-1:0] h_data_o,
  input  logic [DW-1:0] d_data_i
);
  logic          accept;
  logic          complete;
  logic [HW-1:0] out_word;

  pull_hs_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .four_phase_i(four_phase_i),
    .cmd_valid_i (cmd_valid_i),
    .ack_i       (ack_i),
    .cmd_ready_o (cmd_ready_o),
    .busy_o      (busy_o),
    .req_o       (req_o),
    .accept_o    (accept),
    .complete_o  (complete)
  );

  assign out_word = bidir_en_i ? cmd_data_i : '0;

  pull_hs_reg #(.W(HW)) u_out_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .load_i(accept),
    .d_i   (out_word),
    .q_o   (h_data_o)
  );

  pull_hs_reg #(.W(DW)) u_rsp_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .load_i(complete),
    .d_i   (d_data_i),
    .q_o   (rsp_data_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_o <= 1'b0;
    else        done_o <= complete;
  end

  assert_req_known_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown(req_o));
  assert_hdata_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && !ack_i) |=> $stable(h_data_o));
  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  assert_rsp_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(rsp_data_o));
endmodule

// File: tb/pull_hs_requester_tb.sv
`timescale 1ns/1ps
module pull_hs_requester_tb;
  localparam int HW = 16;
  localparam int DW = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          four_phase = 1'b0;
  logic          bidir = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [HW-1:0] cmd_data = '0;
  logic          busy;
  logic          done;
  logic [DW-1:0] rsp_data;
  logic          req;
  logic          ack = 1'b0;
  logic [HW-1:0] h_data;
  logic [DW-1:0] d_data = '0;

  int n_chk = 0;
  int n_err = 0;
  logic [DW-1:0] prev_rsp;

  always #4 clk = ~clk;

  pull_hs_requester #(.HW(HW), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .four_phase_i(four_phase), .bidir_en_i(bidir),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready), .cmd_data_i(cmd_data),
    .busy_o(busy), .done_o(done), .rsp_data_o(rsp_data), .req_o(req),
    .ack_i(ack), .h_data_o(h_data), .d_data_i(d_data)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [HW-1:0] exp_out(logic [HW-1:0] w);
    return bidir ? w : '0;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; ack = 1'b0; cmd_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 req in reset", 32'(req), 0);
    chk("R1 done in reset", 32'(done), 0);
    chk("R1 busy in reset", 32'(busy), 0);
    chk("R1 ready in reset", 32'(cmd_ready), 0);
    chk("R1 rsp in reset", 32'(rsp_data), 0);
    chk("R1 hdata in reset", 32'(h_data), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after release", 32'(cmd_ready), 1);
    prev_rsp = '0;
  endtask

  // Acknowledge with no request: ready must stay low this cycle and the next.
  task automatic stray_ack();
    @(negedge clk); ack = 1'b1; #1;
    chk("R3 ready with ack high", 32'(cmd_ready), 0);
    @(negedge clk); ack = 1'b0; #1;
    chk("R3 ready with past ack high", 32'(cmd_ready), 0);
    @(negedge clk); #1;
    chk("R3 ready after two low cycles", 32'(cmd_ready), 1);
    chk("R3 no request from stray ack", 32'(req), 0);
  endtask

  task automatic xfer(logic [HW-1:0] hd, logic [DW-1:0] dd, int lat, int hold);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_data = hd;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R2 req after accept", 32'(req), 1);
    chk("R5 hdata after accept", 32'(h_data), 32'(exp_out(hd)));
    chk("R3 busy after accept", 32'(busy), 1);
    chk("R3 not ready while busy", 32'(cmd_ready), 0);
    chk("R8 rsp held before ack", 32'(rsp_data), 32'(prev_rsp));
    for (int i = 0; i < lat; i++) begin
      cmd_valid = 1'b1; cmd_data = ~hd;
      @(negedge clk);
      chk("R2 req held until ack", 32'(req), 1);
      chk("R5 hdata stable", 32'(h_data), 32'(exp_out(hd)));
      chk("R3 busy ignores command", 32'(cmd_ready), 0);
      chk("R4 no done before ack", 32'(done), 0);
      chk("R8 rsp held", 32'(rsp_data), 32'(prev_rsp));
    end
    cmd_valid = 1'b0;
    ack = 1'b1; d_data = dd;
    @(negedge clk);
    chk("R4 done pulse", 32'(done), 1);
    chk("R4 rsp captured", 32'(rsp_data), 32'(dd));
    chk("R2 req drops after ack", 32'(req), 0);
    chk("R6 R7 not ready after ack", 32'(cmd_ready), 0);
    prev_rsp = dd;
    d_data = DW'($urandom);
    if (!four_phase) begin
      ack = 1'b0;
      @(negedge clk);
      chk("R4 done one cycle", 32'(done), 0);
      chk("R6 ready after cooldown", 32'(cmd_ready), 1);
    end else begin
      for (int i = 0; i < hold; i++) begin
        @(negedge clk);
        chk("R7 req low while ack high", 32'(req), 0);
        chk("R7 busy while ack high", 32'(busy), 1);
        chk("R4 done one cycle", 32'(done), 0);
      end
      ack = 1'b0;
      @(negedge clk);
      chk("R7 cooldown not ready", 32'(cmd_ready), 0);
      chk("R7 busy in cooldown", 32'(busy), 1);
      @(negedge clk);
      chk("R7 ready after cooldown", 32'(cmd_ready), 1);
    end
    chk("R8 rsp holds after done", 32'(rsp_data), 32'(dd));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int cfg = 0; cfg < 4; cfg++) begin
      four_phase = cfg[0];
      bidir = cfg[1];
      do_reset();
      stray_ack();
      xfer(16'hA5C3, 24'h123456, 0, 0);
      xfer(16'hFFFF, 24'hFFFFFF, 5, 3);
      xfer(16'h0001, 24'h000000, 1, 1);
      for (int k = 0; k < 25; k++)
        xfer(HW'($urandom), DW'($urandom), int'($urandom % 5), int'($urandom % 4));
    end
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule